// File: doc/BRIEF.md
# Debug Transfer Handshake Controller

This block sits between an external debugger and a processor core. It passes 32-bit words through two one-deep mailboxes. The receive mailbox is filled by the debugger and drained by the core. The transmit mailbox is filled by the core and drained by the debugger. A third register holds an instruction word that the block hands to the core on an issue handshake. Each mailbox has a live occupancy flag. An instruction-complete flag tracks whether the core is free to take a new instruction.

On the debugger side there is a single-word bus with select, write, a 2-bit address and a wait output. An access is presented with `dbg_sel` high and held until a cycle in which `dbg_wait` is low; the access takes effect at the clock edge that ends that cycle. A read of the status word reports the live flags and, at the same edge, snapshots them into latched copies. A mode field chooses how debugger accesses are gated:
- **Non-blocking:** accesses are checked against the snapshot and dropped when not ready.
- **Stall:** accesses wait on the live flags.
- **Fast:** accesses wait like stall, and every completed data transfer also issues the held instruction.

The core side uses plain strobes and is the same in every mode.

Top module: `dbg_xfer_ctrl`

## Requirements
- R1: After reset, all flags and their latched copies are 0, the mode is non-blocking (code 00), execute-enable is 0, a status read returns 0 and `issue_valid` is low.
- R2: A completed debugger write to the receive address (1) stores `dbg_wdata` on `core_rx_data` and sets `core_rx_full`. A `core_rx_rd` pulse clears the flag. When both happen in one cycle, the flag ends set.
- R3: A `core_tx_wr` pulse stores `core_tx_data` and sets `core_tx_full`, overwriting any unread word. A completed debugger read of the transmit address (2) returns the stored word and clears the flag. If a core write lands in the same cycle as such a read, the debugger gets the old word and the flag stays set with the new word.
- R4: Address 0 is the status word. A read returns:
  - bit 0: receive-full
  - bit 1: transmit-full
  - bit 2: instruction-complete
  - bits 5:4: mode
  - bit 8: execute-enable
  - all other bits: 0

  The flag values are those before the cycle's updates, and the read copies the three flags into their latched versions. A write loads the mode from bits 5:4 (code 11 is reserved and leaves the mode unchanged) and execute-enable from bit 8.
- R5: In non-blocking mode (00), `dbg_wait` is never raised. The following accesses complete with no effect on any flag or register:
  - a receive write while the latched receive-full is 1
  - a transmit read while the latched transmit-full is 0
  - an instruction write (address 3) while the latched instruction-complete is 0
- R6: In stall (01) and fast (10) modes, `dbg_wait` is high while any of these is pending, and the access completes in the first cycle its condition clears:
  - a receive write with receive-full set
  - a transmit read with transmit-full clear
  - an instruction write with instruction-complete clear
- R7: In fast mode with execute-enable set, each completed receive write or transmit read issues the held instruction. A completed instruction write only loads the register.
- R8: In non-blocking and stall modes, a completed instruction write with execute-enable set issues the new word. An issue raises `issue_valid` for exactly the next cycle, with `issue_instr` carrying the word. It also clears instruction-complete and its latched copy. With execute-enable clear, nothing is issued.
- R9: Instruction-complete is set by a `dbg_entry` or `core_instr_done` pulse. When either pulse coincides with an issue, the flag ends clear.
- R10: The core-side strobes act the same way in every mode and never wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_sel | input | 1 | Debugger access valid |
| dbg_wr | input | 1 | 1 = write, 0 = read |
| dbg_addr | input | 2 | 0 status, 1 receive, 2 transmit, 3 instruction |
| dbg_wdata | input | DATA_W | Debugger write data |
| dbg_rdata | output | DATA_W | Debugger read data |
| dbg_wait | output | 1 | Access must be held |
| core_rx_rd | input | 1 | Core consumes the receive word |
| core_rx_data | output | DATA_W | Receive mailbox word |
| core_rx_full | output | 1 | Receive mailbox occupied |
| core_tx_wr | input | 1 | Core writes the transmit word |
| core_tx_data | input | DATA_W | Core transmit data |
| core_tx_full | output | 1 | Transmit mailbox occupied |
| dbg_entry | input | 1 | Pulse on entry to debug state |
| core_instr_done | input | 1 | Core finished the issued instruction |
| issue_valid | output | 1 | One-cycle instruction issue pulse |
| issue_instr | output | DATA_W | Instruction being issued |

## Verification
The main collision is between the two sides of one mailbox in the same cycle:
- a core transmit write against a debugger transmit read;
- a core receive read against a debugger receive write.

A third collision is an issue against a `dbg_entry` pulse on the instruction-complete flag. The bench provokes each collision by forking the debugger access and the core strobe so that both are sampled at the same edge. It then judges the result through the returned data, the full outputs and a following status read. A behavioural model that runs alongside compares wait, read data, flags and issues on every clock.

// File: rtl/dbg_xfer_pkg.sv
package dbg_xfer_pkg;

  typedef enum logic [1:0] {
    XM_NONBLOCK = 2'b00,
    XM_STALL    = 2'b01,
    XM_FAST     = 2'b10,
    XM_RSVD     = 2'b11
  } xfer_mode_e;

  localparam logic [1:0] RA_STATUS = 2'd0;
  localparam logic [1:0] RA_RXDATA = 2'd1;
  localparam logic [1:0] RA_TXDATA = 2'd2;
  localparam logic [1:0] RA_INSTR  = 2'd3;

  localparam int ST_RX      = 0;
  localparam int ST_TX      = 1;
  localparam int ST_IC      = 2;
  localparam int ST_MODE_LO = 4;
  localparam int ST_MODE_HI = 5;
  localparam int ST_EXEC    = 8;
  localparam int ST_MIN_W   = ST_EXEC + 1;

  // Readiness seen by an access: snapshot in non-blocking mode, live otherwise.
  function automatic logic gate_ready(input xfer_mode_e m, input logic live_rdy,
                                      input logic snap_rdy);
    return (m == XM_NONBLOCK) ? snap_rdy : live_rdy;
  endfunction

  // Only the waiting modes hold the bus while the live flag is not ready.
  function automatic logic hold_bus(input xfer_mode_e m, input logic live_rdy);
    return (m != XM_NONBLOCK) && !live_rdy;
  endfunction

endpackage

// File: rtl/dbg_xfer_flag.sv
module dbg_xfer_flag #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic snap_i,
  input  logic lat_set_i,
  input  logic lat_clr_i,
  output logic live_o,
  output logic lat_o
);
  logic set_eff;

  if (SET_WINS) begin : g_set_first
    assign set_eff = set_i;
  end else begin : g_clr_first
    assign set_eff = set_i & ~clr_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_o <= 1'b0;
      lat_o  <= 1'b0;
    end else begin
      if (set_eff)    live_o <= 1'b1;
      else if (clr_i) live_o <= 1'b0;

      if (snap_i)         lat_o <= live_o;
      else if (lat_set_i) lat_o <= 1'b1;
      else if (lat_clr_i) lat_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_xfer_gate.sv
module dbg_xfer_gate
  import dbg_xfer_pkg::*;
(
  input  logic       sel,
  input  logic       wr,
  input  logic [1:0] addr,
  input  xfer_mode_e mode,
  input  logic       exec_en,
  input  logic       rx_full,
  input  logic       rx_lat,
  input  logic       tx_full,
  input  logic       tx_lat,
  input  logic       ic_full,
  input  logic       ic_lat,
  output logic       st_rd,
  output logic       st_wr,
  output logic       tx_rd_req,
  output logic       rx_wr_ok,
  output logic       tx_rd_ok,
  output logic       it_wr_ok,
  output logic       bus_wait,
  output logic       issue_now
);
  logic rx_wr_req, it_wr_req;

  assign st_rd     = sel && !wr && (addr == RA_STATUS);
  assign st_wr     = sel &&  wr && (addr == RA_STATUS);
  assign rx_wr_req = sel &&  wr && (addr == RA_RXDATA);
  assign tx_rd_req = sel && !wr && (addr == RA_TXDATA);
  assign it_wr_req = sel &&  wr && (addr == RA_INSTR);

  assign rx_wr_ok = rx_wr_req && gate_ready(mode, !rx_full, !rx_lat);
  assign tx_rd_ok = tx_rd_req && gate_ready(mode, tx_full, tx_lat);
  assign it_wr_ok = it_wr_req && gate_ready(mode, ic_full, ic_lat);

  assign bus_wait = (rx_wr_req && hold_bus(mode, !rx_full))
                  | (tx_rd_req && hold_bus(mode, tx_full))
                  | (it_wr_req && hold_bus(mode, ic_full));

  assign issue_now = exec_en &&
                     ((mode == XM_FAST) ? (rx_wr_ok || tx_rd_ok) : it_wr_ok);
endmodule

// File: rtl/dbg_xfer_ctrl.sv
module dbg_xfer_ctrl
  import dbg_xfer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_sel,
  input  logic              dbg_wr,
  input  logic [1:0]        dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic              dbg_wait,
  input  logic              core_rx_rd,
  output logic [DATA_W-1:0] core_rx_data,
  output logic              core_rx_full,
  input  logic              core_tx_wr,
  input  logic [DATA_W-1:0] core_tx_data,
  output logic              core_tx_full,
  input  logic              dbg_entry,
  input  logic              core_instr_done,
  output logic              issue_valid,
  output logic [DATA_W-1:0] issue_instr
);
  localparam int STW = (DATA_W < ST_MIN_W) ? ST_MIN_W : DATA_W;

  xfer_mode_e        mode_q;
  logic              exec_en_q;
  logic [DATA_W-1:0] rx_data_q, tx_data_q, instr_q;
  logic              issue_q;
  logic              rx_full, rx_lat, tx_full, tx_lat, ic_full, ic_lat;
  logic              st_rd, st_wr, tx_rd_req, rx_wr_ok, tx_rd_ok, it_wr_ok;
  logic              bus_wait, issue_now, ic_set;
  logic [STW-1:0]    status_w;

  dbg_xfer_gate u_gate (
    .sel(dbg_sel), .wr(dbg_wr), .addr(dbg_addr), .mode(mode_q),
    .exec_en(exec_en_q), .rx_full(rx_full), .rx_lat(rx_lat),
    .tx_full(tx_full), .tx_lat(tx_lat), .ic_full(ic_full), .ic_lat(ic_lat),
    .st_rd(st_rd), .st_wr(st_wr), .tx_rd_req(tx_rd_req),
    .rx_wr_ok(rx_wr_ok), .tx_rd_ok(tx_rd_ok), .it_wr_ok(it_wr_ok),
    .bus_wait(bus_wait), .issue_now(issue_now)
  );

  // receive: debugger fill wins over core drain
  dbg_xfer_flag #(.SET_WINS(1'b1)) u_rx_flag (
    .clk(clk), .rst_n(rst_n), .set_i(rx_wr_ok), .clr_i(core_rx_rd),
    .snap_i(st_rd), .lat_set_i(rx_wr_ok), .lat_clr_i(1'b0),
    .live_o(rx_full), .lat_o(rx_lat)
  );

  // transmit: core fill wins over debugger drain
  dbg_xfer_flag #(.SET_WINS(1'b1)) u_tx_flag (
    .clk(clk), .rst_n(rst_n), .set_i(core_tx_wr), .clr_i(tx_rd_ok),
    .snap_i(st_rd), .lat_set_i(1'b0), .lat_clr_i(tx_rd_ok),
    .live_o(tx_full), .lat_o(tx_lat)
  );

  // instruction complete: a new issue wins over completion events
  assign ic_set = dbg_entry | core_instr_done;
  dbg_xfer_flag #(.SET_WINS(1'b0)) u_ic_flag (
    .clk(clk), .rst_n(rst_n), .set_i(ic_set), .clr_i(issue_now),
    .snap_i(st_rd), .lat_set_i(1'b0), .lat_clr_i(issue_now),
    .live_o(ic_full), .lat_o(ic_lat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= XM_NONBLOCK;
      exec_en_q <= 1'b0;
      rx_data_q <= '0;
      tx_data_q <= '0;
      instr_q   <= '0;
      issue_q   <= 1'b0;
    end else begin
      issue_q <= issue_now;
      if (rx_wr_ok)   rx_data_q <= dbg_wdata;
      if (core_tx_wr) tx_data_q <= core_tx_data;
      if (it_wr_ok)   instr_q   <= dbg_wdata;
      if (st_wr) begin
        exec_en_q <= dbg_wdata[ST_EXEC];
        if (dbg_wdata[ST_MODE_HI:ST_MODE_LO] != XM_RSVD)
          mode_q <= xfer_mode_e'(dbg_wdata[ST_MODE_HI:ST_MODE_LO]);
      end
    end
  end

  always_comb begin
    status_w = '0;
    status_w[ST_RX] = rx_full;
    status_w[ST_TX] = tx_full;
    status_w[ST_IC] = ic_full;
    status_w[ST_MODE_HI:ST_MODE_LO] = mode_q;
    status_w[ST_EXEC] = exec_en_q;
  end

  always_comb begin
    if (st_rd)          dbg_rdata = status_w[DATA_W-1:0];
    else if (tx_rd_req) dbg_rdata = tx_data_q;
    else                dbg_rdata = '0;
  end

  assign dbg_wait     = bus_wait;
  assign core_rx_data = rx_data_q;
  assign core_rx_full = rx_full;
  assign core_tx_full = tx_full;
  assign issue_valid  = issue_q;
  assign issue_instr  = instr_q;
endmodule

// File: rtl/dbg_xfer_chk.sv
module dbg_xfer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dbg_sel,
  input logic       dbg_wr,
  input logic [1:0] dbg_addr,
  input logic       dbg_wait,
  input logic       core_rx_rd,
  input logic       core_tx_wr,
  input logic       dbg_entry,
  input logic       issue_valid,
  input logic [1:0] mode,
  input logic       exec_en,
  input logic       rx_full,
  input logic       tx_full,
  input logic       ic_full,
  input logic       rx_wr_ok,
  input logic       issue_now
);
  a_r5_nb_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> !dbg_wait);

  a_r6_rx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_sel && dbg_wr && dbg_addr == 2'd1 && mode != 2'b00 && rx_full) |-> dbg_wait);

  a_r6_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_sel && !dbg_wr && dbg_addr == 2'd2 && mode != 2'b00 && !tx_full) |-> dbg_wait);

  a_r3_core_fill: assert property (@(posedge clk) disable iff (!rst_n)
    core_tx_wr |=> tx_full);

  a_r2_core_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rx_rd && !rx_wr_ok) |=> !rx_full);

  a_r8_issue_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    issue_now |=> issue_valid);

  a_r8_issue_needs_exec: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> $past(exec_en));

  a_r9_entry_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_entry && !issue_now) |=> ic_full);

  a_r9_issue_clears: assert property (@(posedge clk) disable iff (!rst_n)
    issue_now |=> !ic_full);
endmodule

bind dbg_xfer_ctrl dbg_xfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_sel(dbg_sel), .dbg_wr(dbg_wr),
  .dbg_addr(dbg_addr), .dbg_wait(dbg_wait), .core_rx_rd(core_rx_rd),
  .core_tx_wr(core_tx_wr), .dbg_entry(dbg_entry), .issue_valid(issue_valid),
  .mode(mode_q), .exec_en(exec_en_q), .rx_full(rx_full), .tx_full(tx_full),
  .ic_full(ic_full), .rx_wr_ok(rx_wr_ok), .issue_now(issue_now)
);

// File: tb/dbg_xfer_ctrl_tb_top.sv
module dbg_xfer_ctrl_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dbg_sel, dbg_wr;
  logic [1:0]    dbg_addr;
  logic [DW-1:0] dbg_wdata, dbg_rdata;
  logic          dbg_wait;
  logic          core_rx_rd, core_rx_full, core_tx_wr, core_tx_full;
  logic [DW-1:0] core_rx_data, core_tx_data;
  logic          dbg_entry, core_instr_done, issue_valid;
  logic [DW-1:0] issue_instr;

  always #10 clk = ~clk;

  dbg_xfer_ctrl #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dbg_sel(dbg_sel), .dbg_wr(dbg_wr),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .dbg_wait(dbg_wait), .core_rx_rd(core_rx_rd), .core_rx_data(core_rx_data),
    .core_rx_full(core_rx_full), .core_tx_wr(core_tx_wr),
    .core_tx_data(core_tx_data), .core_tx_full(core_tx_full),
    .dbg_entry(dbg_entry), .core_instr_done(core_instr_done),
    .issue_valid(issue_valid), .issue_instr(issue_instr)
  );

  int checks = 0, fails = 0, issues_seen = 0;
  logic [31:0] last_issue = '0;
  logic [31:0] rd_a, rd_b;
  int wt_a, wt_b;

  // behavioural reference state
  int          m_mode;
  bit          m_exec, m_rx, m_tx, m_ic, m_rxl, m_txl, m_icl, m_iv;
  logic [31:0] m_rxd, m_txd, m_it, m_iw;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h time=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return 32'(m_rx) + 32'(m_tx) * 2 + 32'(m_ic) * 4 + 32'(m_mode) * 16 + 32'(m_exec) * 256;
  endfunction

  // Whether the access currently on the bus is allowed to take effect.
  function automatic bit m_allowed(input int kind);
    bit live, snap;
    case (kind)
      1: begin live = !m_rx; snap = !m_rxl; end
      2: begin live = m_tx;  snap = m_txl;  end
      default: begin live = m_ic; snap = m_icl; end
    endcase
    return (m_mode == 0) ? snap : live;
  endfunction

  function automatic int kind_now();
    if (!dbg_sel) return -1;
    if (dbg_addr == 2'd0) return dbg_wr ? 10 : 0;
    if (dbg_addr == 2'd1) return dbg_wr ? 1 : -1;
    if (dbg_addr == 2'd2) return dbg_wr ? -1 : 2;
    return dbg_wr ? 3 : -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_exec = 0; m_rx = 0; m_tx = 0; m_ic = 0;
      m_rxl = 0; m_txl = 0; m_icl = 0; m_iv = 0;
      m_rxd = 0; m_txd = 0; m_it = 0; m_iw = 0;
    end else begin
      int k;
      bit ok, iss, n_rx, n_tx, n_ic, n_rxl, n_txl, n_icl;
      k   = kind_now();
      ok  = (k == 1 || k == 2 || k == 3) && m_allowed(k);
      iss = m_exec && ((m_mode == 2) ? (ok && k != 3) : (ok && k == 3));
      n_rx = m_rx; n_tx = m_tx; n_ic = m_ic;
      n_rxl = m_rxl; n_txl = m_txl; n_icl = m_icl;
      if (core_rx_rd) n_rx = 0;
      if (ok && k == 1) begin n_rx = 1; n_rxl = 1; m_rxd = dbg_wdata; end
      if (ok && k == 2) begin n_tx = 0; n_txl = 0; end
      if (core_tx_wr) begin n_tx = 1; m_txd = core_tx_data; end
      if (dbg_entry || core_instr_done) n_ic = 1;
      if (ok && k == 3) m_it = dbg_wdata;
      if (iss) begin n_ic = 0; n_icl = 0; end
      if (k == 0) begin n_rxl = m_rx; n_txl = m_tx; n_icl = m_ic; end
      if (k == 10) begin
        m_exec = dbg_wdata[8];
        if (dbg_wdata[5:4] != 2'b11) m_mode = int'(dbg_wdata[5:4]);
      end
      m_iv = iss; m_iw = m_it;
      m_rx = n_rx; m_tx = n_tx; m_ic = n_ic;
      m_rxl = n_rxl; m_txl = n_txl; m_icl = n_icl;
    end
  end

  // cycle-by-cycle comparison in the middle of each cycle
  always @(negedge clk) begin
    if (rst_n) begin
      int k;
      bit exp_wait;
      k = kind_now();
      exp_wait = (m_mode != 0) && (k == 1 || k == 2 || k == 3) && !m_allowed(k);
      chk((m_mode == 0) ? "R5 wait" : "R6 wait", 32'(dbg_wait), 32'(exp_wait));
      if (k == 0) chk("R4 status", dbg_rdata, exp_status());
      if (k == 2 && m_allowed(2)) chk("R3 tx data", dbg_rdata, m_txd);
      chk("R2 rx data", core_rx_data, m_rxd);
      chk("R2 rx full", 32'(core_rx_full), 32'(m_rx));
      chk("R3 tx full", 32'(core_tx_full), 32'(m_tx));
      chk("R8 issue", 32'(issue_valid), 32'(m_iv));
      if (m_iv) chk("R8 issue word", issue_instr, m_iw);
      if (issue_valid) begin issues_seen++; last_issue = issue_instr; end
    end
  end

  task automatic dbg_op(input logic w, input logic [1:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int waited);
    bit done;
    waited = 0; rd = '0;
    dbg_sel = 1; dbg_wr = w; dbg_addr = a; dbg_wdata = wd;
    do begin
      @(negedge clk);
      done = !dbg_wait;
      rd = dbg_rdata;
      if (!done) waited++;
      @(posedge clk); #2;
    end while (!done);
    dbg_sel = 0; dbg_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic core_rd();
    core_rx_rd = 1; @(posedge clk); #2; core_rx_rd = 0;
  endtask

  task automatic core_wr(input logic [31:0] d);
    core_tx_wr = 1; core_tx_data = d; @(posedge clk); #2; core_tx_wr = 0;
  endtask

  task automatic pulse_entry();
    dbg_entry = 1; @(posedge clk); #2; dbg_entry = 0;
  endtask

  task automatic pulse_done();
    core_instr_done = 1; @(posedge clk); #2; core_instr_done = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n0;
    rst_n = 0; dbg_sel = 0; dbg_wr = 0; dbg_addr = 0; dbg_wdata = 0;
    core_rx_rd = 0; core_tx_wr = 0; core_tx_data = 0;
    dbg_entry = 0; core_instr_done = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R1 reset state
    chk("R1 issue idle", 32'(issue_valid), 0);
    dbg_op(0, 2'd0, 0, rd_a, wt_a);
    chk("R1 status zero", rd_a, 0);

    // R5 non-blocking receive gating on the snapshot
    dbg_op(1, 2'd1, 32'hA5A5_0001, rd_a, wt_a);
    chk("R2 rx stored", core_rx_data, 32'hA5A5_0001);
    dbg_op(1, 2'd1, 32'h0000_2222, rd_a, wt_a);
    chk("R5 rx drop keeps data", core_rx_data, 32'hA5A5_0001);
    core_rd();
    chk("R2 core drain", 32'(core_rx_full), 0);
    dbg_op(1, 2'd1, 32'h0000_3333, rd_a, wt_a);
    chk("R5 stale snapshot drops", 32'(core_rx_full), 0);
    dbg_op(0, 2'd0, 0, rd_a, wt_a);
    dbg_op(1, 2'd1, 32'h0000_3333, rd_a, wt_a);
    chk("R5 fresh snapshot accepts", core_rx_data, 32'h0000_3333);
    core_rd();

    // R2 fill and drain in one cycle
    dbg_op(0, 2'd0, 0, rd_a, wt_a);
    fork
      dbg_op(1, 2'd1, 32'h0000_4444, rd_a, wt_a);
      core_rd();
    join
    chk("R2 set wins", 32'(core_rx_full), 1);
    chk("R2 collided data", core_rx_data, 32'h0000_4444);
    core_rd();

    // R3 transmit path, overwrite, and snapshot gating
    core_wr(32'h0000_1111);
    core_wr(32'h0000_2222);
    dbg_op(0, 2'd2, 0, rd_a, wt_a);
    chk("R5 tx read dropped", 32'(core_tx_full), 1);
    dbg_op(0, 2'd0, 0, rd_a, wt_a);
    chk("R4 status tx bit", rd_a, 32'h0000_0002);
    dbg_op(0, 2'd2, 0, rd_a, wt_a);
    chk("R3 overwritten word", rd_a, 32'h0000_2222);
    chk("R3 drain clears", 32'(core_tx_full), 0);
    core_wr(32'h0000_5555);
    dbg_op(0, 2'd0, 0, rd_a, wt_a);
    fork
      dbg_op(0, 2'd2, 0, rd_b, wt_b);
      core_wr(32'h0000_6666);
    join
    chk("R3 collision old word", rd_b, 32'h0000_5555);
    chk("R3 collision stays full", 32'(core_tx_full), 1);
    dbg_op(0, 2'd0, 0, rd_a, wt_a);
    dbg_op(0, 2'd2, 0, rd_a, wt_a);
    chk("R3 collision new word", rd_a, 32'h0000_6666);

    // R4 status write, reserved mode ignored
    dbg_op(1, 2'd0, 32'h0000_0110, rd_a, wt_a);
    dbg_op(0, 2'd0, 0, rd_a, wt_a);
    chk("R4 stall and exec", rd_a, 32'h0000_0110);
    dbg_op(1, 2'd0, 32'h0000_0130, rd_a, wt_a);
    dbg_op(0, 2'd0, 0, rd_a, wt_a);
    chk("R4 reserved kept", rd_a, 32'h0000_0110);

    // R6 stall mode waits on live flags
    dbg_op(1, 2'd0, 32'h0000_0010, rd_a, wt_a);
    dbg_op(1, 2'd1, 32'h0000_7777, rd_a, wt_a);
    fork
      dbg_op(1, 2'd1, 32'h0000_8888, rd_a, wt_a);
      begin idle(3); core_rd(); end
    join
    chk("R6 rx waited", 32'(wt_a > 0), 1);
    chk("R6 rx completed", core_rx_data, 32'h0000_8888);
    core_rd();
    fork
      dbg_op(0, 2'd2, 0, rd_a, wt_a);
      begin idle(2); core_wr(32'h0000_9999); end
    join
    chk("R6 tx waited", 32'(wt_a > 0), 1);
    chk("R6 tx word", rd_a, 32'h0000_9999);
    core_wr(32'h0000_ABCD);
    chk("R10 core fill in stall", 32'(core_tx_full), 1);
    dbg_op(0, 2'd2, 0, rd_a, wt_a);

    // R8 / R9 issue in non-blocking mode
    dbg_op(1, 2'd0, 32'h0000_0100, rd_a, wt_a);
    pulse_entry();
    dbg_op(0, 2'd0, 0, rd_a, wt_a);
    chk("R9 entry sets", rd_a, 32'h0000_0104);
    n0 = issues_seen;
    dbg_op(1, 2'd3, 32'h0000_00E1, rd_a, wt_a);
    idle(1);
    chk("R8 one issue", 32'(issues_seen - n0), 1);
    chk("R8 issued word", last_issue, 32'h0000_00E1);
    dbg_op(0, 2'd0, 0, rd_a, wt_a);
    chk("R8 complete cleared", rd_a, 32'h0000_0100);
    dbg_op(1, 2'd3, 32'h0000_00E2, rd_a, wt_a);
    idle(1);
    chk("R5 instr dropped", 32'(issues_seen - n0), 1);
    pulse_done();
    dbg_op(0, 2'd0, 0, rd_a, wt_a);
    chk("R9 done sets", rd_a, 32'h0000_0104);
    dbg_op(1, 2'd0, 32'h0000_0000, rd_a, wt_a);
    dbg_op(1, 2'd3, 32'h0000_00E3, rd_a, wt_a);
    idle(1);
    chk("R8 exec off no issue", 32'(issues_seen - n0), 1);
    dbg_op(1, 2'd0, 32'h0000_0100, rd_a, wt_a);
    dbg_op(0, 2'd0, 0, rd_a, wt_a);
    fork
      dbg_op(1, 2'd3, 32'h0000_00E4, rd_a, wt_a);
      pulse_entry();
    join
    dbg_op(0, 2'd0, 0, rd_a, wt_a);
    chk("R9 issue beats entry", rd_a, 32'h0000_0100);

    // R7 fast mode
    pulse_done();
    dbg_op(1, 2'd0, 32'h0000_0120, rd_a, wt_a);
    n0 = issues_seen;
    dbg_op(1, 2'd3, 32'h0000_00F1, rd_a, wt_a);
    idle(1);
    chk("R7 instr load only", 32'(issues_seen - n0), 0);
    dbg_op(1, 2'd1, 32'h0000_AAAA, rd_a, wt_a);
    idle(1);
    chk("R7 rx issues", 32'(issues_seen - n0), 1);
    chk("R7 held word", last_issue, 32'h0000_00F1);
    core_rd();
    core_wr(32'h0000_BBBB);
    dbg_op(0, 2'd2, 0, rd_a, wt_a);
    idle(1);
    chk("R7 tx issues", 32'(issues_seen - n0), 2);
    chk("R7 tx word", rd_a, 32'h0000_BBBB);

    idle(2);
    finish_run();
  end
endmodule